// File: doc/BRIEF.md
# Partitioned Inter-Processor Interrupt Unit

This unit lets the cores of a multi-core cluster interrupt each other. Each core owns a 16-bit cause register. A write to one of sixteen set addresses raises the cause bit chosen by the address in every core whose bit is 1 in the write data. A core clears its own cause bits by writing ones to its cause address. The same simple register bus also reads back the cause registers and a partition register.

The sixteen cause bits fall into four fixed groups of 1, 3, 4 and 8 bits. Each group is OR-reduced. A 2-bit field of the partition register steers the group to one of three per-core interrupt lines, or drops it. Groups that share a line are ORed together. The lines are registered, level-sensitive outputs. A line stays high as long as any cause bit routed to it is set.

Top module: `ipi_unit`

## Requirements
- R1: A write to address 0x140+k (k = 0..15) sets cause bit k in every core c for which write-data bit c is 1, and leaves all other cause bits unchanged.
- R2: A write to address 0x100+c clears the cause bits of core c that are 1 in write-data bits [15:0]. Other cores are not affected.
- R3: The four groups are bit 0 (group 0), bits 3:1 (group 1), bits 7:4 (group 2) and bits 15:8 (group 3). Any set bit in a group makes that group active.
- R4: The partition register is written and read at 0x190. Bits [1:0], [3:2], [5:4] and [7:6] select the output line (0, 1 or 2) for groups 0, 1, 2 and 3 in that order.
- R5: A group whose field holds 3 drives no output line.
- R6: Groups that select the same line are ORed onto it, so the line stays high while any one of them is active.
- R7: After reset, every cause register, the partition register and every output line is zero.
- R8: Set-data bits at or above NUM_CORES, and cause addresses 0x100+c with c >= NUM_CORES, have no effect. Those addresses read as zero.
- R9: Output bits [3c+2:3c] are core c's lines. They are registered: they follow the cause and partition state one clock after that state changes, and they hold while the state is unchanged.
- R10: A read strobe returns, one clock later on the read-data port, the cause register (0x100+c) or the partition register (0x190). Any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after bus_rd |
| irq_out | output | 3*NUM_CORES | Three interrupt lines per core |

## Verification
A write sampled at clock edge N changes the cause or partition state at edge N. The interrupt lines that depend on it change at edge N+1, and read data requested at edge N appears right after edge N. The bench drives on falling edges and lets one further falling edge pass after each write before it compares the lines. The expected lines come from a model that sums over lines rather than over groups. The level check waits several extra cycles and confirms that the lines have held.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CAUSE_W   = 16;
  localparam int NUM_LINES = 3;
  localparam int NUM_GRP   = 4;
  localparam int PART_W    = 2 * NUM_GRP;
  localparam int CAUSE_BASE = 'h100;
  localparam int SET_BASE   = 'h140;
  localparam int PART_ADDR  = 'h190;

  // OR-reduce the four fixed clusters (1,3,4,8 bits)
  function automatic logic [NUM_GRP-1:0] group_any(input logic [CAUSE_W-1:0] c);
    group_any[0] = c[0];
    group_any[1] = |c[3:1];
    group_any[2] = |c[7:4];
    group_any[3] = |c[15:8];
  endfunction

  // Steer each active group to the line its 2-bit field names; 3 drops it
  function automatic logic [NUM_LINES-1:0] steer(input logic [NUM_GRP-1:0] g,
                                                 input logic [PART_W-1:0] p);
    logic [NUM_LINES-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      case (p[2*i +: 2])
        2'd0: acc[0] = acc[0] | g[i];
        2'd1: acc[1] = acc[1] | g[i];
        2'd2: acc[2] = acc[2] | g[i];
        default: ;
      endcase
    end
    return acc;
  endfunction
endpackage

// File: rtl/ipi_reg_if.sv
module ipi_reg_if
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [CAUSE_W-1:0]   set_vec,
  output logic [NUM_CORES-1:0] set_core,
  output logic [NUM_CORES-1:0] clr_core,
  output logic [CAUSE_W-1:0]   clr_vec,
  output logic                 part_wr
);
  localparam logic [ADDR_W-1:0] SET_LO = ADDR_W'(SET_BASE);
  localparam logic [ADDR_W-1:0] SET_HI = ADDR_W'(SET_BASE + CAUSE_W);

  logic set_hit;
  assign set_hit = bus_wr && (bus_addr >= SET_LO) && (bus_addr < SET_HI);

  always_comb begin
    set_vec = '0;
    if (set_hit) set_vec[bus_addr[3:0]] = 1'b1;
  end

  assign set_core = set_hit ? bus_wdata[NUM_CORES-1:0] : '0;
  assign clr_vec  = bus_wdata[CAUSE_W-1:0];
  assign part_wr  = bus_wr && (bus_addr == ADDR_W'(PART_ADDR));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_clr
    assign clr_core[c] = bus_wr && (bus_addr == ADDR_W'(CAUSE_BASE + c));
  end
endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
  import ipi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic               clr_en,
  input  logic [CAUSE_W-1:0] clr_vec,
  output logic [CAUSE_W-1:0] cause
);
  logic [CAUSE_W-1:0] clr_eff, set_eff;
  assign clr_eff = clr_en ? clr_vec : '0;
  assign set_eff = set_en ? set_vec : '0;

  // set wins over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= (cause & ~clr_eff) | set_eff;
  end
endmodule

// File: rtl/ipi_router.sv
module ipi_router
  import ipi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CAUSE_W-1:0]   cause,
  input  logic [PART_W-1:0]    part,
  output logic [NUM_LINES-1:0] lines
);
  logic [NUM_GRP-1:0] grp;
  assign grp = group_any(cause);

  always_ff @(posedge clk) begin
    if (!rst_n) lines <= '0;
    else        lines <= steer(grp, part);
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NUM_LINES*NUM_CORES-1:0] irq_out
);
  localparam int CAUSE_FLAT_W = CAUSE_W * NUM_CORES;

  logic [CAUSE_W-1:0]      set_vec, clr_vec;
  logic [NUM_CORES-1:0]    set_core, clr_core;
  logic                    part_wr;
  logic [PART_W-1:0]       part_q;
  logic [CAUSE_FLAT_W-1:0] cause_flat;

  ipi_reg_if #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_if (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .set_vec(set_vec), .set_core(set_core), .clr_core(clr_core),
    .clr_vec(clr_vec), .part_wr(part_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       part_q <= '0;
    else if (part_wr) part_q <= bus_wdata[PART_W-1:0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_cause_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_core[c]), .set_vec(set_vec),
      .clr_en(clr_core[c]), .clr_vec(clr_vec),
      .cause(cause_flat[c*CAUSE_W +: CAUSE_W])
    );
    ipi_router u_rt (
      .clk(clk), .rst_n(rst_n),
      .cause(cause_flat[c*CAUSE_W +: CAUSE_W]), .part(part_q),
      .lines(irq_out[c*NUM_LINES +: NUM_LINES])
    );
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(PART_ADDR)) rd_mux[PART_W-1:0] = part_q;
    for (int c = 0; c < NUM_CORES; c++)
      if (bus_addr == ADDR_W'(CAUSE_BASE + c))
        rd_mux[CAUSE_W-1:0] = cause_flat[c*CAUSE_W +: CAUSE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [CAUSE_W*NUM_CORES-1:0]   cause_flat,
  input logic [PART_W-1:0]              part_q,
  input logic [NUM_LINES*NUM_CORES-1:0] irq_out
);
  logic set_wr, ghost_clr;
  assign set_wr = bus_wr && bus_addr >= ADDR_W'(SET_BASE) && bus_addr < ADDR_W'(SET_BASE + CAUSE_W);
  assign ghost_clr = bus_wr && bus_addr >= ADDR_W'(CAUSE_BASE + NUM_CORES) && bus_addr < ADDR_W'(SET_BASE);

  AST_PART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(PART_ADDR)) |=> part_q == $past(bus_wdata[PART_W-1:0])); // R4

  AST_GHOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ghost_clr |=> $stable(cause_flat)); // R8

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_wr && bus_wdata[c]) |=>
        ((cause_flat[c*CAUSE_W +: CAUSE_W] & (16'h1 << $past(bus_addr[3:0]))) != 16'h0)); // R1

    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(CAUSE_BASE + c)) |=>
        ((cause_flat[c*CAUSE_W +: CAUSE_W] & $past(bus_wdata[CAUSE_W-1:0])) == 16'h0)); // R2

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(cause_flat[c*CAUSE_W +: CAUSE_W])); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_flat[c*CAUSE_W +: CAUSE_W] == 16'h0) |=> irq_out[c*NUM_LINES +: NUM_LINES] == 3'b000); // R9
  end
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cause_flat(cause_flat), .part_q(part_q), .irq_out(irq_out)
);

// File: tb/tb_ipi_unit.sv
`timescale 1ns/1ps
module tb_ipi_unit;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3*N-1:0] irq_out;

  int errors = 0, checks = 0;
  logic [15:0] m_cause [N];
  logic [7:0]  m_part;

  always #2.5 clk = ~clk;

  ipi_unit #(.NUM_CORES(N)) dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference: for each line, collect groups whose field names it
  function automatic logic [2:0] ref_lines(input logic [15:0] c, input logic [7:0] p);
    logic [3:0] act;
    logic [2:0] r;
    act = {c[15:8] != 0, c[7:4] != 0, c[3:1] != 0, c[0]};
    r = 3'b000;
    for (int l = 0; l < 3; l++)
      for (int g = 0; g < 4; g++)
        if (p[2*g +: 2] == l[1:0] && act[g]) r[l] = 1'b1;
    return r;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    if (a >= 10'h140 && a < 10'h150) begin
      for (int c = 0; c < N; c++) if (d[c]) m_cause[c][a[3:0]] = 1'b1;
    end else if (a >= 10'h100 && a < 10'h100 + N) m_cause[a - 10'h100] &= ~d[15:0];
    else if (a == 10'h190) m_part = d[7:0];
    @(negedge clk); // lines settle one edge after the state
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic chk_lines(input string req);
    for (int c = 0; c < N; c++)
      chk(req, {29'h0, irq_out[3*c +: 3]}, {29'h0, ref_lines(m_cause[c], m_part)});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R7 irq", {20'h0, irq_out}, 32'h0);
    rd(10'h100, d); chk("R7 cause0", d, 32'h0);
    rd(10'h190, d); chk("R7 part", d, 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] d;
    wr(10'h140, 32'h5);               // bit0 into cores 0 and 2
    chk_lines("R1");
    chk("R1 core0 line0", {31'h0, irq_out[0]}, 32'h1);
    chk("R1 core1 quiet", {29'h0, irq_out[5:3]}, 32'h0);
    rd(10'h102, d); chk("R10 cause2", d, 32'h1);
    repeat (5) @(negedge clk);
    chk("R9 level held", {31'h0, irq_out[6]}, 32'h1);
    wr(10'h100, 32'h1);               // core0 clears its bit
    chk("R2 core0 cleared", {29'h0, irq_out[2:0]}, 32'h0);
    chk("R2 core2 kept", {31'h0, irq_out[6]}, 32'h1);
    chk_lines("R2");
    wr(10'h102, 32'hFFFF);
  endtask

  task automatic t_groups;
    wr(10'h142, 32'h2);               // bit2 (group1) core1
    chk("R3 group1 line0", {29'h0, irq_out[5:3]}, 32'h1);
    wr(10'h14F, 32'h2);               // bit15 (group3) core1
    wr(10'h101, 32'h0004);
    chk("R3 group3 alone", {29'h0, irq_out[5:3]}, 32'h1);
    wr(10'h101, 32'hFFFF);
    chk_lines("R3");
  endtask

  task automatic t_partition;
    logic [31:0] d;
    wr(10'h190, 32'hC9);              // g0->1 g1->2 g2->0 g3->drop
    rd(10'h190, d); chk("R10 part", d, 32'hC9);
    wr(10'h148, 32'h8);               // group3 in core3
    chk("R5 dropped", {29'h0, irq_out[11:9]}, 32'h0);
    wr(10'h145, 32'h8);               // group2 -> line0
    chk("R4 g2 line0", {29'h0, irq_out[11:9]}, 32'h1);
    wr(10'h140, 32'h8);               // group0 -> line1
    chk("R4 g0 line1", {29'h0, irq_out[11:9]}, 32'h3);
    wr(10'h143, 32'h8);               // group1 -> line2
    chk("R4 g1 line2", {29'h0, irq_out[11:9]}, 32'h7);
    chk_lines("R4");
    wr(10'h103, 32'hFFFF);
  endtask

  task automatic t_shared;
    wr(10'h190, 32'h14);              // g1,g2 -> line1
    wr(10'h141, 32'h4);
    wr(10'h144, 32'h4);
    chk("R6 shared", {29'h0, irq_out[8:6]}, 32'h2);
    wr(10'h102, 32'h0002);
    chk("R6 still", {29'h0, irq_out[8:6]}, 32'h2);
    wr(10'h102, 32'h0010);
    chk("R6 gone", {29'h0, irq_out[8:6]}, 32'h0);
  endtask

  task automatic t_ghost;
    logic [31:0] d;
    wr(10'h146, 32'hFFFF_FFF0);       // only bits above the cores
    chk("R8 ghost set", {20'h0, irq_out}, 32'h0);
    rd(10'h100, d); chk("R8 core0 untouched", d, 32'h0);
    wr(10'h146, 32'h1);
    wr(10'h104, 32'hFFFF);            // no core 4
    rd(10'h100, d); chk("R8 ghost clear", d, 32'h0040);
    rd(10'h104, d); chk("R8 ghost read", d, 32'h0);
    chk_lines("R8");
  endtask

  initial begin
    for (int c = 0; c < N; c++) m_cause[c] = '0;
    m_part = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_groups();
    t_partition();
    t_shared();
    t_ghost();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule